// File: doc/BRIEF.md
# Majority-Clocked Triple Shift-Register Keystream Generator

This block produces a pseudorandom keystream one bit per step from three external-feedback (Fibonacci) shift registers of 19, 22 and 23 bits, 64 state bits in all. On each step a single clocking bit is taken from each register and a two-of-three vote is formed over them. Only the registers whose clocking bit agrees with the vote advance; the others hold. So every step moves two or three registers, and the stepping pattern depends on the state.

The surrounding logic loads all 64 state bits at once with a load strobe, typically after its own key and IV mixing. It then raises the step input once for each keystream bit it needs, usually 228 in a row for a frame. After every accepted step the output bit is the XOR of the most significant bits of the three registers, and a valid flag marks it for one cycle. A scan port shows the full state at all times for test.

Top module: `mcg_keygen`

## Requirements
- R1: After reset, all 64 state bits are zero, and `ks_bit` and `ks_valid` are low.
- R2: When `load` is high at a clock edge, all 64 state bits take the value of `load_state` at that edge. This applies even if `step` is also high. `ks_valid` is low in the following cycle.
- R3: On a step, the clocking bits are bit 8 of register A, bit 10 of register B and bit 10 of register C. A register advances exactly when its clocking bit equals the majority of the three clocking bits. Registers that do not advance keep their value.
- R4: When a register advances, it shifts toward its most significant bit and a feedback bit enters at bit 0. The feedback bit is the XOR of these taps: bits 13, 16, 17 and 18 for A; bits 20 and 21 for B; bits 7, 20, 21 and 22 for C.
- R5: Every step, meaning `step` high with `load` low, moves at least two registers.
- R6: In the cycle after a step, `ks_valid` is high and `ks_bit` equals A[18] ^ B[21] ^ C[22] taken from the state after the step.
- R7: With `step` and `load` both low, the state and `ks_bit` hold, and `ks_valid` is low in the next cycle.
- R8: `scan_state` and `load_state` use the same packing: A at bits 18:0, B at bits 40:19, C at bits 63:41.
- R9: A run of 228 consecutive steps from any loaded state yields the keystream that R3, R4 and R6 define. A state that is all zero stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load strobe; has priority over step |
| load_state | input | 64 | Parallel state to load (A 18:0, B 40:19, C 63:41) |
| step | input | 1 | Advance the generator by one keystream bit |
| ks_bit | output | 1 | Keystream bit from the latest step |
| ks_valid | output | 1 | High for one cycle after each accepted step |
| scan_state | output | 64 | Full register state, same packing as load_state |

## Verification
All eight combinations of the three clocking bits are forced through loaded states. This separates the cases where all three registers advance from the three cases where exactly one register stalls, and it exercises the feedback taps of each register on its own. Load with and without a simultaneous step shows that load has priority. Idle cycles show that the state holds. Long runs of 228 steps from random loaded states, plus one all-zero state, compare every keystream bit and the final state against an arithmetic model in the bench.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  localparam int NREG = 3;
  localparam int REG_LEN [NREG] = '{19, 22, 23};
  localparam int CLK_TAP [NREG] = '{8, 10, 10};
  // feedback tap masks, bit n set means stage n feeds the XOR
  localparam logic [31:0] FB_MASK [NREG] = '{32'h0007_2000, 32'h0030_0000, 32'h0070_0080};

  function automatic int reg_base(int idx);
    int acc;
    acc = 0;
    for (int i = 0; i < idx; i++) acc += REG_LEN[i];
    return acc;
  endfunction

  localparam int STATE_W = reg_base(NREG);

  // parity of the tapped stages
  function automatic logic fb_bit(logic [31:0] s, logic [31:0] m);
    return ^(s & m);
  endfunction

  // two-of-three vote
  function automatic logic vote3(logic x, logic y, logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/mcg_lfsr_stage.sv
module mcg_lfsr_stage #(
  parameter int          LEN  = 19,
  parameter int          CTAP = 8,
  parameter logic [31:0] FBM  = 32'h0007_2000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] load_val,
  input  logic           shift,
  output logic [LEN-1:0] state,
  output logic           clk_bit,
  output logic           end_nxt
);
  import mcg_pkg::*;

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] adv;
  logic [LEN-1:0] nxt;
  logic           fb;

  always_comb begin
    fb  = fb_bit(32'(state_q), FBM);
    adv = {state_q[LEN-2:0], fb};
    if (load)       nxt = load_val;
    else if (shift) nxt = adv;
    else            nxt = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= nxt;
  end

  assign state   = state_q;
  assign clk_bit = state_q[CTAP];
  assign end_nxt = nxt[LEN-1];
endmodule

// File: rtl/mcg_clock_vote.sv
module mcg_clock_vote #(
  parameter int N = 3
) (
  input  logic [N-1:0] clk_bits,
  output logic [N-1:0] shift_en,
  output logic         maj
);
  import mcg_pkg::*;

  assign maj = vote3(clk_bits[0], clk_bits[1], clk_bits[2]);

  for (genvar g = 0; g < N; g++) begin : g_en
    assign shift_en[g] = ~(clk_bits[g] ^ maj);
  end
endmodule

// File: rtl/mcg_ks_out.sv
module mcg_ks_out #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_go,
  input  logic [N-1:0] end_bits,
  output logic         ks_bit,
  output logic         ks_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= step_go;
      if (step_go) ks_bit <= ^end_bits;
    end
  end
endmodule

// File: rtl/mcg_keygen.sv
module mcg_keygen
  import mcg_pkg::*;
#(
  parameter int SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_state,
  input  logic          step,
  output logic          ks_bit,
  output logic          ks_valid,
  output logic [SW-1:0] scan_state
);
  logic            step_go;
  logic [NREG-1:0] clk_bits;
  logic [NREG-1:0] shift_en;
  logic [NREG-1:0] end_bits;
  logic            maj;

  assign step_go = step & ~load;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int LEN  = REG_LEN[g];
    localparam int BASE = reg_base(g);
    logic [LEN-1:0] st;

    mcg_lfsr_stage #(
      .LEN (LEN),
      .CTAP(CLK_TAP[g]),
      .FBM (FB_MASK[g])
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_val(load_state[BASE +: LEN]),
      .shift   (step_go & shift_en[g]),
      .state   (st),
      .clk_bit (clk_bits[g]),
      .end_nxt (end_bits[g])
    );

    assign scan_state[BASE +: LEN] = st;
  end

  mcg_clock_vote #(.N(NREG)) u_vote (
    .clk_bits(clk_bits),
    .shift_en(shift_en),
    .maj     (maj)
  );

  mcg_ks_out #(.N(NREG)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_go (step_go),
    .end_bits(end_bits),
    .ks_bit  (ks_bit),
    .ks_valid(ks_valid)
  );
endmodule

// File: rtl/mcg_keygen_chk.sv
module mcg_keygen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic        step,
  input logic [63:0] load_state,
  input logic [2:0]  clk_bits,
  input logic [2:0]  shift_en,
  input logic        ks_valid,
  input logic [63:0] scan_state
);
  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (scan_state == $past(load_state)) && !ks_valid);

  a_r3_agree_a: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> shift_en[0] == ((clk_bits[0] == clk_bits[1]) || (clk_bits[0] == clk_bits[2])));

  a_r3_stall_a: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !shift_en[0]) |=> $stable(scan_state[18:0]));

  a_r3_stall_c: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !shift_en[2]) |=> $stable(scan_state[63:41]));

  a_r5_two_move: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> $countones(shift_en) >= 2);

  a_r6_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ks_valid);

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(scan_state) && !ks_valid);
endmodule

bind mcg_keygen mcg_keygen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load      (load),
  .step      (step),
  .load_state(load_state),
  .clk_bits  (clk_bits),
  .shift_en  (shift_en),
  .ks_valid  (ks_valid),
  .scan_state(scan_state)
);

// File: tb/sim_mcg_keygen.sv
`timescale 1ns/1ps
module sim_mcg_keygen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        step = 1'b0;
  logic [63:0] load_state = '0;
  logic        ks_bit, ks_valid;
  logic [63:0] scan_state;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] mdl;

  always #10 clk = ~clk;

  mcg_keygen u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .load_state(load_state),
    .step(step), .ks_bit(ks_bit), .ks_valid(ks_valid), .scan_state(scan_state)
  );

  // reference model: written from the requirements
  function automatic logic [63:0] ref_step(logic [63:0] s);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    logic m;
    a = s[18:0];
    b = s[40:19];
    c = s[63:41];
    m = (a[8] + b[10] + c[10]) >= 2;
    if (a[8] == m)  a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
    if (b[10] == m) b = {b[20:0], b[21] ^ b[20]};
    if (c[10] == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
    return {c, b, a};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [63:0] v, bit with_step);
    load_state = v;
    load = 1'b1;
    step = with_step;
    @(negedge clk);
    load = 1'b0;
    step = 1'b0;
    mdl = v;
    check(scan_state == v, "R2/R8 load", scan_state, v);
    check(ks_valid == 1'b0, "R2 valid after load", 64'(ks_valid), 64'd0);
  endtask

  task automatic do_step(string req);
    logic e;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    mdl = ref_step(mdl);
    e = mdl[18] ^ mdl[40] ^ mdl[63];
    check(ks_valid && ks_bit == e, req, {62'd0, ks_valid, ks_bit}, {62'd0, 1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] hold;
    logic        kb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scan_state == 64'd0, "R1 state", scan_state, 64'd0);
    check(!ks_valid && !ks_bit, "R1 outputs", {62'd0, ks_valid, ks_bit}, 64'd0);

    // R3 R4 R5 R6: sweep all eight clocking bit patterns
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 4; r++) begin
        v = {$urandom, $urandom};
        v[8] = p[0];
        v[19 + 10] = p[1];
        v[41 + 10] = p[2];
        do_load(v, 0);
        do_step("R3/R4/R6 pattern step");
        check(scan_state == mdl, "R3/R4/R5 state after step", scan_state, mdl);
      end
    end

    // R2 load overrides a simultaneous step
    v = {$urandom, $urandom};
    do_load(v, 1);

    // R7 idle holds state and keystream bit
    do_step("R6 before idle");
    hold = scan_state;
    kb = ks_bit;
    repeat (5) @(negedge clk);
    check(scan_state == hold, "R7 state hold", scan_state, hold);
    check(ks_bit == kb && !ks_valid, "R7 output hold", {62'd0, ks_valid, ks_bit}, {63'd0, kb});

    // R9 frames of 228 steps from random states
    for (int f = 0; f < 16; f++) begin
      do_load({$urandom, $urandom}, 0);
      for (int k = 0; k < 228; k++) do_step("R9 frame keystream");
      check(scan_state == mdl, "R9 frame end state", scan_state, mdl);
    end

    // R9 all-zero state stays zero
    do_load(64'd0, 0);
    for (int k = 0; k < 20; k++) do_step("R9 zero keystream");
    check(scan_state == 64'd0, "R9 zero stays", scan_state, 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule